// File: doc/BRIEF.md
# Diagonally Pipelined Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It is a grid of identical cells. Each cell ANDs one bit of `in_a` with one bit of `in_b` and passes that bit through a full adder together with an incoming sum bit and an incoming carry bit. Row r of the grid holds the cells for bit r of `in_a`. Between rows, sums and carries are kept in carry-save form, so each carry moves one column toward the more significant end. A final row of N one-bit adders resolves the remaining carry-save pair, one bit position per stage.

Register cuts fall along the diagonals of the skewed cell wall, and every stage holds one full-adder level. Triangles of skew registers delay each operand bit until the stage that consumes it. A matching set of deskew registers holds each finished product bit until the last stage. Every path from input to output therefore crosses exactly 2N registers. The block accepts one operand pair per clock with no stalls. A valid flag travels beside the data, and `out_valid` marks the cycle in which `out_prod` holds the product of an accepted pair.

Top module: `mul_diag_array`

## Requirements
- R1: For every pair sampled with `in_valid` high at a rising clock edge, `out_prod` equals the unsigned product `in_a * in_b`, all 2N bits.
- R2: `out_valid` is high in exactly the cycle that comes LATENCY = 2N clock cycles after the cycle in which the accepted pair was presented. It is low in every cycle that has no such pair.
- R3: A new pair may be presented in every cycle with no gap. The results then appear in consecutive cycles, one per cycle, in the order the pairs were presented.
- R4: `rst` is synchronous and active high. When it is high at a rising edge, that edge discards every pair in flight, including a pair presented in the same cycle. `out_valid` is low in the next cycle and stays low until a pair accepted after the reset reaches the output.
- R5: Operands presented while `in_valid` is low are ignored. They raise no `out_valid` and do not change the products of pairs accepted just before or after them.
- R6: Extreme operands give exact results. Zero times any value gives 0. One times x gives x. All-ones times all-ones gives 2^(2N) - 2^(N+1) + 1. The single top bit times itself gives 2^(2N-2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears the valid pipeline |
| in_valid | input | 1 | High when `in_a`/`in_b` hold a pair to multiply |
| in_a | input | N | Unsigned multiplicand |
| in_b | input | N | Unsigned multiplier |
| out_valid | output | 1 | High in the cycle that `out_prod` holds an accepted product |
| out_prod | output | 2N | Unsigned 2N-bit product, registered |

## Verification
Two events can fall in the same clock edge. One is a reset. The other is a fresh pair being accepted while earlier pairs are still partway through the diagonal stages. The bench provokes this by streaming valid pairs without a gap, then raising `rst` for one cycle while `in_valid` stays high. It then judges that no result from before or during that edge ever appears and that `out_valid` stays low for a full latency window. A second overlap is the normal one in a streaming run: a result leaves at the same edge a new pair enters. Here every product is compared against a bench-computed value that was queued in the cycle of its presentation, so a lost, repeated or reordered result shows up as a mismatch.

// File: rtl/mul_pkg.sv
package mul_pkg;

  // Result of one full-adder cell: carry toward the next column and the sum bit.
  typedef struct packed {
    logic cout;
    logic sum;
  } fa_t;

  function automatic fa_t full_add(input logic x, input logic y, input logic z);
    fa_t r;
    r.sum  = x ^ y ^ z;
    r.cout = (x & y) | (x & z) | (y & z);
    return r;
  endfunction

endpackage

// File: rtl/mul_skew_line.sv
// Plain delay line used to skew operand bits into later diagonals and to
// deskew finished product bits toward the output. DEPTH must be at least 1.
module mul_skew_line #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    pipe[0] <= d;
    for (int k = 1; k < DEPTH; k++) begin
      pipe[k] <= pipe[k-1];
    end
  end

  assign q = pipe[DEPTH-1];

endmodule

// File: rtl/mul_row_stage.sv
// One row of the cell array: N AND/full-adder cells working in carry-save
// form, followed by the stage register. Depth is one full adder.
module mul_row_stage
  import mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_in,
  input  logic         a_bit,
  input  logic [N-1:0] b_in,
  input  logic [N-2:0] sh_in,   // upper sum bits of the previous row, weight r+j
  input  logic [N-1:0] c_in,    // carries of the previous row, weight r+j
  output logic         v_out,
  output logic [N-2:0] sh_out,
  output logic [N-1:0] c_out,
  output logic         p_out    // finished product bit of weight r
);

  localparam int VW = N + 2;

  logic [N-1:0] pp;
  logic [N-1:0] sh_full;
  logic [N-1:0] s_nx;
  logic [N-1:0] c_nx;

  assign pp      = b_in & {N{a_bit}};
  assign sh_full = {1'b0, sh_in};

  generate
    for (genvar j = 0; j < N; j++) begin : g_cell
      fa_t r;
      assign r       = full_add(pp[j], sh_full[j], c_in[j]);
      assign s_nx[j] = r.sum;
      assign c_nx[j] = r.cout;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) v_out <= 1'b0;
    else     v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    sh_out <= s_nx[N-1:1];
    c_out  <= c_nx;
    p_out  <= s_nx[0];
  end

  // The row must conserve arithmetic value: outputs equal inputs plus a*b row.
  logic [VW-1:0] val_out;
  logic [VW-1:0] val_in;
  always_comb begin
    val_out = VW'(s_nx) + (VW'(c_nx) << 1);
    val_in  = VW'(sh_in) + VW'(c_in) + (a_bit ? VW'(b_in) : VW'(0));
    assert_row_sum_R1: assert (val_out == val_in)
      else $error("row stage lost value: %0d vs %0d", val_out, val_in);
  end

endmodule

// File: rtl/mul_merge_stage.sv
// One bit position of the final carry-save resolver, registered.
module mul_merge_stage
  import mul_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic v_in,
  input  logic x_bit,
  input  logic y_bit,
  input  logic cy_in,
  output logic v_out,
  output logic sum_out,
  output logic cy_out
);

  fa_t r;
  assign r = full_add(x_bit, y_bit, cy_in);

  always_ff @(posedge clk) begin
    if (rst) v_out <= 1'b0;
    else     v_out <= v_in;
  end

  always_ff @(posedge clk) begin
    sum_out <= r.sum;
    cy_out  <= r.cout;
  end

endmodule

// File: rtl/mul_diag_array.sv
// Unsigned N x N array multiplier with diagonal pipeline cuts.
// N rows of carry-save cells, then N single-bit resolver stages; every
// input-to-output path crosses exactly LATENCY = 2N registers. Needs N >= 2.
module mul_diag_array
  import mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N-1:0]   in_a,
  input  logic [N-1:0]   in_b,
  output logic           out_valid,
  output logic [2*N-1:0] out_prod
);

  localparam int LATENCY = 2 * N;
  localparam int SW      = N - 1;
  localparam int CW      = $clog2(LATENCY + 2);

  // ---------------- multiplier operand skew (shared chain) ----------------
  logic [N-1:0] b_q [N-1];
  always_ff @(posedge clk) begin
    b_q[0] <= in_b;
    for (int k = 1; k < N - 1; k++) begin
      b_q[k] <= b_q[k-1];
    end
  end

  // ---------------- carry-save rows ----------------
  logic [SW-1:0] sh_w [N+1];
  logic [N-1:0]  c_w  [N+1];
  logic          v_w  [N+1];
  logic          p_w  [N];

  assign sh_w[0] = '0;
  assign c_w[0]  = '0;
  assign v_w[0]  = in_valid;

  generate
    for (genvar r = 0; r < N; r++) begin : g_row
      logic         a_bit_r;
      logic [N-1:0] b_r;

      if (r == 0) begin : g_first
        assign a_bit_r = in_a[0];
        assign b_r     = in_b;
      end else begin : g_later
        mul_skew_line #(.W(1), .DEPTH(r)) u_askew (
          .clk (clk),
          .d   (in_a[r]),
          .q   (a_bit_r)
        );
        assign b_r = b_q[r-1];
      end

      mul_row_stage #(.N(N)) u_row (
        .clk    (clk),
        .rst    (rst),
        .v_in   (v_w[r]),
        .a_bit  (a_bit_r),
        .b_in   (b_r),
        .sh_in  (sh_w[r]),
        .c_in   (c_w[r]),
        .v_out  (v_w[r+1]),
        .sh_out (sh_w[r+1]),
        .c_out  (c_w[r+1]),
        .p_out  (p_w[r])
      );

      // low product bit r waits for the rest of the pipeline
      mul_skew_line #(.W(1), .DEPTH(LATENCY - 1 - r)) u_lo (
        .clk (clk),
        .d   (p_w[r]),
        .q   (out_prod[r])
      );
    end
  endgenerate

  // ---------------- carry-save resolver, one bit per stage ----------------
  logic m_v  [N+1];
  logic m_cy [N+1];
  logic m_s  [N];

  assign m_v[0]  = v_w[N];
  assign m_cy[0] = 1'b0;

  generate
    for (genvar k = 0; k < N; k++) begin : g_mrg
      logic x_k;
      logic y_k;

      if (k == 0) begin : g_direct
        assign x_k = sh_w[N][0];
        assign y_k = c_w[N][0];
      end else begin : g_skewed
        if (k < SW) begin : g_xs
          mul_skew_line #(.W(1), .DEPTH(k)) u_xs (
            .clk (clk),
            .d   (sh_w[N][k]),
            .q   (x_k)
          );
        end else begin : g_xz
          assign x_k = 1'b0;
        end
        mul_skew_line #(.W(1), .DEPTH(k)) u_ys (
          .clk (clk),
          .d   (c_w[N][k]),
          .q   (y_k)
        );
      end

      mul_merge_stage u_mrg (
        .clk     (clk),
        .rst     (rst),
        .v_in    (m_v[k]),
        .x_bit   (x_k),
        .y_bit   (y_k),
        .cy_in   (m_cy[k]),
        .v_out   (m_v[k+1]),
        .sum_out (m_s[k]),
        .cy_out  (m_cy[k+1])
      );

      if (k == N - 1) begin : g_hi_last
        assign out_prod[N+k] = m_s[k];
      end else begin : g_hi_skew
        mul_skew_line #(.W(1), .DEPTH(N - 1 - k)) u_hi (
          .clk (clk),
          .d   (m_s[k]),
          .q   (out_prod[N+k])
        );
      end
    end
  endgenerate

  assign out_valid = m_v[N];

  // ---------------- checks ----------------
  // Pairs accepted but not yet delivered.
  logic [CW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CW'(in_valid) - CW'(out_valid);
  end

  assert_final_carry_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !m_cy[N]);

  assert_inflight_bound_R2: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(LATENCY));

  assert_no_orphan_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != '0));

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen) begin
      assert_reset_clear_R4: assert (!out_valid)
        else $error("out_valid high right after reset");
    end
  end

endmodule

// File: tb/tb_mul_diag_array.sv
`timescale 1ns/1ps
module tb_mul_diag_array;

  localparam int N   = 8;
  localparam int LAT = 2 * N;
  localparam int PW  = 2 * N;
  localparam int HD  = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [N-1:0]  in_a = '0;
  logic [N-1:0]  in_b = '0;
  logic          out_valid;
  logic [PW-1:0] out_prod;

  always #2 clk = ~clk;   // 250 MHz

  mul_diag_array #(.N(N)) dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_prod  (out_prod)
  );

  int            cyc    = 0;
  int            checks = 0;
  int            fails  = 0;
  bit            done   = 1'b0;
  logic          hv [HD];
  logic [PW-1:0] hp [HD];

  function automatic logic [PW-1:0] ref_prod(input logic [N-1:0] a, input logic [N-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  task automatic check_out(input string tag);
    logic          ev;
    logic [PW-1:0] ep;
    ev = 1'b0;
    ep = '0;
    if (cyc >= LAT) begin
      ev = hv[(cyc - LAT) % HD];
      ep = hp[(cyc - LAT) % HD];
    end
    checks++;
    if (out_valid !== ev) begin
      fails++;
      $display("FAIL %s cycle %0d: out_valid=%0b expected %0b", tag, cyc, out_valid, ev);
    end
    if (ev) begin
      checks++;
      if (out_prod !== ep) begin
        fails++;
        $display("FAIL %s cycle %0d: out_prod=%0h expected %0h", tag, cyc, out_prod, ep);
      end
    end
  endtask

  // Drive one cycle, record the expectation, then sample mid-cycle.
  task automatic step(input logic v, input logic [N-1:0] a, input logic [N-1:0] b,
                      input string tag);
    int slot;
    slot = cyc % HD;
    in_valid = v;
    in_a     = a;
    in_b     = b;
    if (rst) begin
      for (int k = 0; k < HD; k++) hv[k] = 1'b0;
    end
    hv[slot] = v && !rst;
    hp[slot] = ref_prod(a, b);
    @(posedge clk);
    cyc++;
    @(negedge clk);
    check_out(tag);
  endtask

  function automatic logic [N-1:0] rnd();
    return N'($urandom);
  endfunction

  initial begin
    logic [N-1:0] ones;
    logic [N-1:0] top;
    int unused_seed;
    ones = '1;
    top  = {1'b1, {(N-1){1'b0}}};
    unused_seed = $urandom(32'd6004);
    for (int k = 0; k < HD; k++) begin
      hv[k] = 1'b0;
      hp[k] = '0;
    end

    // R4: reset state, out_valid low
    rst = 1'b1;
    repeat (3) step(1'b1, rnd(), rnd(), "R4");
    rst = 1'b0;

    // R6: extreme operands, back to back
    step(1'b1, '0, '0, "R6");
    step(1'b1, ones, ones, "R6");
    step(1'b1, N'(1), ones, "R6");
    step(1'b1, ones, N'(1), "R6");
    step(1'b1, '0, ones, "R6");
    step(1'b1, ones, '0, "R6");
    step(1'b1, top, top, "R6");
    step(1'b1, N'(1), N'(1), "R6");

    // R5: garbage operands with in_valid low, then alternating
    repeat (20) step(1'b0, rnd(), rnd(), "R5");
    for (int k = 0; k < 40; k++) step(1'(k % 2), rnd(), rnd(), "R5");

    // R1 R3: back-to-back random stream
    repeat (400) step(1'b1, rnd(), rnd(), "R1 R3");

    // R2: random valid pattern
    repeat (300) step(1'($urandom % 2), rnd(), rnd(), "R2");

    // R4: reset while data in flight and a pair presented in the same cycle
    repeat (6) step(1'b1, rnd(), rnd(), "R4");
    rst = 1'b1;
    step(1'b1, ones, ones, "R4");
    rst = 1'b0;
    repeat (LAT + 4) step(1'b0, rnd(), rnd(), "R4");
    repeat (20) step(1'b1, rnd(), rnd(), "R1");

    // drain
    repeat (LAT + 2) step(1'b0, rnd(), rnd(), "R2");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: run incomplete, expected finish before timeout");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule